// File: doc/BRIEF.md
# Segmented Fetch Address and Branch Unit

This unit produces the instruction fetch address of a small 16-bit processor. The address is formed from a 4-bit code segment register in the upper bits and a 12-bit program offset in the lower bits. Each time the fetch stage strobes `adv`, the unit looks at the instruction word that comes with the strobe. If the word is in the branch class and its condition holds, the unit loads a new target. Otherwise the offset steps forward by one.

A branch names one of four general registers. The unit puts that index on `rf_sel`, and the register file returns the register's contents on `rf_data` in the same cycle. A near branch replaces only the offset. A far branch replaces the segment as well.

The instruction stream enters as one word per `adv` strobe. `adv` acts as the valid qualifier. There is no ready signal, because the unit takes every strobed word in the cycle it arrives, so the fetch stage never sees back-pressure. All state changes on the rising edge of one common clock.

Top module: `pcb_fetch_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `fetch_addr` to 0x0000, and the reset has priority over `adv`.
- R2: `fetch_addr` is the segment in bits 15..12 joined to the offset in bits 11..0. While `adv` is low, `fetch_addr` holds its value and `br_taken` stays low, whatever the instruction word is.
- R3: When `adv` is high and the word is not in the branch class, the offset increments by one and the segment is kept.
- R4: The offset wraps from 0xFFF to 0x000 and the segment does not change. A taken branch in the same cycle wins over the wrap.
- R5: A word is in the branch class when bit 15 is 0 and bits 14..13 equal 2'b10. `rf_sel` always shows bits 7..6 of `instr`, which is the index of the target register.
- R6: Branch opcode 4'b0000 in bits 12..9 is always taken.
- R7: Branch opcodes 1, 2, 3 and 4 are taken when, respectively, `flag_z` is 1, `flag_z` is 0, `flag_c` is 1, and `flag_c` is 0.
- R8: Branch opcodes 5 to 15 are never taken. For these the offset increments as in R3.
- R9: A taken branch with bit 8 equal to 0 (near) loads `rf_data[11:0]` into the offset and keeps the segment.
- R10: A taken branch with bit 8 equal to 1 (far) loads `rf_data[11:0]` into the offset and `rf_data[15:12]` into the segment.
- R11: Bits 5..0 of a branch word have no effect on `br_taken` or on the next address.
- R12: `br_taken` is combinational. It is high in the same cycle as a strobed branch-class word whose condition holds, and the new address appears after that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Fetch-advance strobe; qualifies `instr` |
| instr | input | 16 | Instruction word for this step, bit 15 first |
| flag_z | input | 1 | Zero condition flag |
| flag_c | input | 1 | Carry condition flag |
| rf_sel | output | 2 | Index of the branch-target register |
| rf_data | input | 16 | Contents of the register chosen by `rf_sel` |
| fetch_addr | output | 16 | Segment and offset fetch address |
| br_taken | output | 1 | This strobe causes a branch |

## Verification
Two functions can fall in the same cycle: the sequential offset step at its 0xFFF wrap point and a taken branch. The bench provokes this by first placing the offset at 0xFFF with a near branch. It then strobes a taken branch, and later a reserved-opcode branch, at that offset. The address after the edge must be the branch target in the first case and 0x000 with the segment unchanged in the second. Far branches are also checked against a following wrap, to confirm that the reloaded segment survives the carry out of the offset.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int INSTR_W = 16;
  localparam int SEG_W   = 4;
  localparam int OFF_W   = 12;
  localparam int RIDX_W  = 2;
  localparam int OPC_W   = 4;
  localparam int ADDR_W  = SEG_W + OFF_W;
  localparam int REG_W   = ADDR_W;

  // Field positions; the first instruction bit is the most significant one
  localparam int POS_TOP = INSTR_W - 1;
  localparam int CLS_HI  = INSTR_W - 2;
  localparam int CLS_LO  = INSTR_W - 3;
  localparam int OPC_HI  = INSTR_W - 4;
  localparam int OPC_LO  = OPC_HI - OPC_W + 1;
  localparam int FAR_BIT = OPC_LO - 1;
  localparam int RIDX_HI = FAR_BIT - 1;
  localparam int RIDX_LO = RIDX_HI - RIDX_W + 1;

  localparam logic [1:0] CLS_BRANCH = 2'b10;

  typedef enum logic [OPC_W-1:0] {
    BOP_ALWAYS = 4'd0,
    BOP_ZSET   = 4'd1,
    BOP_ZCLR   = 4'd2,
    BOP_CSET   = 4'd3,
    BOP_CCLR   = 4'd4
  } br_opc_e;

  typedef struct packed {
    logic              hit;
    logic [OPC_W-1:0]  opc;
    logic              far;
    logic [RIDX_W-1:0] ridx;
  } br_fields_t;
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output br_fields_t         fields
);
  // low bits of a branch word carry nothing for this unit
  logic ign_unused;
  assign ign_unused = ^instr[RIDX_LO-1:0];

  always_comb begin
    fields.hit  = (instr[POS_TOP] == 1'b0) && (instr[CLS_HI:CLS_LO] == CLS_BRANCH);
    fields.opc  = instr[OPC_HI:OPC_LO];
    fields.far  = instr[FAR_BIT];
    fields.ridx = instr[RIDX_HI:RIDX_LO];
  end
endmodule

// File: rtl/pcb_cond.sv
module pcb_cond
  import pcb_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic             zf,
  input  logic             cf,
  output logic             pass
);
  always_comb begin
    case (opc)
      BOP_ALWAYS: pass = 1'b1;
      BOP_ZSET:   pass = zf;
      BOP_ZCLR:   pass = ~zf;
      BOP_CSET:   pass = cf;
      BOP_CCLR:   pass = ~cf;
      default:    pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcb_addr_reg.sv
module pcb_addr_reg #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  localparam int AW   = SEG_W + OFF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic          load_seg,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] addr
);
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      off_q <= '0;
    end else if (load) begin
      off_q <= target[OFF_W-1:0];
      if (load_seg) seg_q <= target[AW-1:OFF_W];
    end else if (step) begin
      off_q <= off_q + OFF_W'(1);
    end
  end

  assign addr = {seg_q, off_q};
endmodule

// File: rtl/pcb_fetch_unit.sv
module pcb_fetch_unit
  import pcb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [INSTR_W-1:0] instr,
  input  logic               flag_z,
  input  logic               flag_c,
  output logic [RIDX_W-1:0]  rf_sel,
  input  logic [REG_W-1:0]   rf_data,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               br_taken
);
  br_fields_t dec;
  logic       cond_ok;

  pcb_decode u_dec (
    .instr  (instr),
    .fields (dec)
  );

  pcb_cond u_cond (
    .opc  (dec.opc),
    .zf   (flag_z),
    .cf   (flag_c),
    .pass (cond_ok)
  );

  assign br_taken = adv & dec.hit & cond_ok;
  assign rf_sel   = dec.ridx;

  pcb_addr_reg #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W)
  ) u_areg (
    .clk      (clk),
    .rst      (rst),
    .step     (adv),
    .load     (br_taken),
    .load_seg (dec.far),
    .target   (rf_data[ADDR_W-1:0]),
    .addr     (fetch_addr)
  );
endmodule

// File: rtl/pcb_fetch_chk.sv
module pcb_fetch_chk
  import pcb_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               adv,
  input logic [INSTR_W-1:0] instr,
  input logic               flag_z,
  input logic               flag_c,
  input logic [RIDX_W-1:0]  rf_sel,
  input logic [REG_W-1:0]   rf_data,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               br_taken
);
  logic is_br;
  assign is_br = !instr[POS_TOP] && (instr[CLS_HI:CLS_LO] == CLS_BRANCH);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(fetch_addr));

  a_r3_step_offset: assert property (@(posedge clk) disable iff (rst)
    (adv && !br_taken) |=>
      (fetch_addr[OFF_W-1:0] == $past(fetch_addr[OFF_W-1:0]) + OFF_W'(1)) &&
      (fetch_addr[ADDR_W-1:OFF_W] == $past(fetch_addr[ADDR_W-1:OFF_W])));

  a_r8_reserved_untaken: assert property (@(posedge clk) disable iff (rst)
    (adv && is_br && (instr[OPC_HI:OPC_LO] > 4'd4)) |-> !br_taken);

  a_r9_near_target: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !instr[FAR_BIT]) |=>
      (fetch_addr[OFF_W-1:0] == $past(rf_data[OFF_W-1:0])) &&
      (fetch_addr[ADDR_W-1:OFF_W] == $past(fetch_addr[ADDR_W-1:OFF_W])));

  a_r10_far_target: assert property (@(posedge clk) disable iff (rst)
    (br_taken && instr[FAR_BIT]) |=> fetch_addr == $past(rf_data[ADDR_W-1:0]));

  a_r12_taken_qualified: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (adv && is_br));

  a_r6_always_taken: assert property (@(posedge clk) disable iff (rst)
    (adv && is_br && (instr[OPC_HI:OPC_LO] == 4'd0)) |-> br_taken);
endmodule

bind pcb_fetch_unit pcb_fetch_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .adv        (adv),
  .instr      (instr),
  .flag_z     (flag_z),
  .flag_c     (flag_c),
  .rf_sel     (rf_sel),
  .rf_data    (rf_data),
  .fetch_addr (fetch_addr),
  .br_taken   (br_taken)
);

// File: tb/tb_pcb_fetch_unit.sv
module tb_pcb_fetch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic [1:0]  rf_sel;
  logic [15:0] rf_data = 16'h0000;
  logic [15:0] fetch_addr;
  logic        br_taken;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_addr = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcb_fetch_unit dut (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .instr      (instr),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .rf_sel     (rf_sel),
    .rf_data    (rf_data),
    .fetch_addr (fetch_addr),
    .br_taken   (br_taken)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cond_model(input logic [3:0] opc, input logic z, input logic c);
    case (opc)
      4'd0: return 1'b1;
      4'd1: return z;
      4'd2: return !z;
      4'd3: return c;
      4'd4: return !c;
      default: return 1'b0;
    endcase
  endfunction

  // one strobe (or idle cycle), checking taken, select and next address
  task automatic drive(input logic a, input logic [15:0] w, input logic z, input logic c,
                       input logic [15:0] rd, input string req);
    logic hit;
    logic tk;
    @(negedge clk);
    adv = a; instr = w; flag_z = z; flag_c = c; rf_data = rd;
    #1;
    hit = !w[15] && (w[14:13] == 2'b10);
    tk  = a && hit && cond_model(w[12:9], z, c);
    chk({req, " taken"}, {15'd0, br_taken}, {15'd0, tk});
    chk("R5 select", {14'd0, rf_sel}, {14'd0, w[7:6]});
    if (a) begin
      if (tk) exp_addr = w[8] ? rd : {exp_addr[15:12], rd[11:0]};
      else    exp_addr = {exp_addr[15:12], exp_addr[11:0] + 12'd1};
    end
    @(negedge clk);
    adv = 1'b0;
    chk({req, " addr"}, fetch_addr, exp_addr);
  endtask

  function automatic logic [15:0] bw(input logic [3:0] opc, input logic far, input logic [1:0] ri);
    return {1'b0, 2'b10, opc, far, ri, 6'b000000};
  endfunction

  task automatic t_reset();
    rst = 1'b1; adv = 1'b1; instr = bw(4'd0, 1'b1, 2'd0); rf_data = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 during reset", fetch_addr, 16'h0000);
    rst = 1'b0; adv = 1'b0;
    @(negedge clk);
    exp_addr = 16'h0000;
    chk("R1 after release", fetch_addr, 16'h0000);
    chk("R1 taken idle", {15'd0, br_taken}, 16'h0000);
  endtask

  task automatic t_sequential();
    drive(1'b1, 16'h8000, 1'b0, 1'b0, 16'h1234, "R3 load-store word");
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 16'h1234, "R3 alu word");
    drive(1'b1, 16'h6000, 1'b1, 1'b1, 16'h1234, "R3 io word");
    drive(1'b1, 16'hC000, 1'b1, 1'b0, 16'h1234, "R5 top bit set");
  endtask

  task automatic t_hold();
    drive(1'b0, bw(4'd0, 1'b1, 2'd3), 1'b0, 1'b0, 16'hBEEF, "R2 idle branch word");
    drive(1'b0, 16'h0000, 1'b1, 1'b1, 16'h5555, "R2 idle alu word");
  endtask

  task automatic t_near_far();
    drive(1'b1, bw(4'd0, 1'b0, 2'd1), 1'b0, 1'b0, 16'hA123, "R9 near jump");
    drive(1'b1, bw(4'd0, 1'b1, 2'd2), 1'b1, 1'b0, 16'h7456, "R10 far jump");
    drive(1'b1, bw(4'd0, 1'b0, 2'd0), 1'b0, 1'b1, 16'h9ABC, "R6 near keeps segment");
  endtask

  task automatic t_conditions();
    for (int op = 1; op <= 4; op++) begin
      for (int fl = 0; fl < 4; fl++) begin
        drive(1'b1, bw(op[3:0], 1'b0, 2'd1), fl[0], fl[1], 16'h0100 + 16'(op * 16 + fl), "R7 condition");
      end
    end
  endtask

  task automatic t_reserved();
    for (int op = 5; op <= 15; op++) begin
      drive(1'b1, bw(op[3:0], 1'b1, 2'd2), op[0], op[1], 16'hF00F, "R8 reserved opcode");
    end
  endtask

  task automatic t_ignored();
    drive(1'b1, bw(4'd1, 1'b0, 2'd1) | 16'h003F, 1'b1, 1'b0, 16'h0321, "R11 low bits set taken");
    drive(1'b1, bw(4'd2, 1'b0, 2'd1) | 16'h002A, 1'b1, 1'b0, 16'h0777, "R11 low bits set untaken");
  endtask

  task automatic t_wrap();
    drive(1'b1, bw(4'd0, 1'b1, 2'd0), 1'b0, 1'b0, 16'h5FFF, "R10 far to edge");
    drive(1'b1, 16'h8001, 1'b0, 1'b0, 16'h0000, "R4 wrap keeps segment");
    drive(1'b1, bw(4'd0, 1'b0, 2'd0), 1'b0, 1'b0, 16'h0FFF, "R9 near to edge");
    drive(1'b1, bw(4'd0, 1'b0, 2'd3), 1'b0, 1'b0, 16'h0ABC, "R4 branch beats wrap");
    drive(1'b1, bw(4'd0, 1'b0, 2'd0), 1'b0, 1'b0, 16'h0FFF, "R9 near to edge again");
    drive(1'b1, bw(4'd9, 1'b1, 2'd0), 1'b0, 1'b0, 16'h1234, "R4 untaken wraps");
    drive(1'b1, bw(4'd0, 1'b0, 2'd0), 1'b0, 1'b0, 16'h0FFF, "R9 near to edge third");
    drive(1'b1, bw(4'd3, 1'b1, 2'd2), 1'b0, 1'b1, 16'h2010, "R12 far at edge");
  endtask

  task automatic t_midreset();
    @(negedge clk);
    rst = 1'b1; adv = 1'b1; instr = 16'h8000;
    @(negedge clk);
    rst = 1'b0; adv = 1'b0;
    exp_addr = 16'h0000;
    chk("R1 mid-run reset", fetch_addr, 16'h0000);
    drive(1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, "R3 step after reset");
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_hold();
    t_near_far();
    t_conditions();
    t_reserved();
    t_ignored();
    t_wrap();
    t_midreset();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule